// File: doc/BRIEF.md
# DRAM Command Timing Gate

This block stands between a first-in first-out command queue and the DRAM command bus. In every cycle it looks at the command at the head of the queue. It picks, from a table set up at boot, the set of timing constraints that apply to that kind of command. It lets the command through only when every counter in that set has run down to zero. A command that goes through is driven onto the bus one cycle later. In the same cycle, the counters that this command starts are reloaded from their configured gaps.

A sleep command is consumed without reaching the bus. It then holds back all issue for the number of cycles it carries. A readiness output tells the scheduler above whether the head command will be free to issue within a programmable number of cycles.

Timing gaps, the per-command mask table and the readiness threshold sit in configuration registers. This lets one design serve several speed grades. Constraints are tracked for a single bank and a single rank.

Top module: `dtg_timing_gate`

## Requirements
- R1: `head_pop` is high only when `head_valid` is high, and only in the cycle in which the head command is consumed. When a non-sleep command is consumed, `bus_cmd` and `bus_addr` carry its code and its argument in the following cycle.
- R2: Command codes are NOP=0, RD=1, WR=2, ACT=3, PRE=4, REF=5, PWR=6 and SLP=7. Constraint indices are RCD=0, RAS=1, RC=2, RP=3, RRD=4, CCD=5, WTR=6, WR=7, RTP=8, RTW=9, XP=10 and RFC=11. A non-sleep head command issues only when every constraint selected by its mask has a counter of zero. The default masks are:
  - RD: {RCD, CCD, WTR, XP}
  - WR: {RCD, CCD, RTW, XP}
  - ACT: {RP, RC, RRD, RFC, XP}
  - PRE: {RAS, WR, RTP, XP}
  - REF: {RP, RC, RFC, XP}
  - NOP, PWR and SLP select nothing.
- R3: When a command issues, it reloads the counters it starts:
  - ACT: RCD, RAS, RC, RRD
  - PRE: RP
  - RD: CCD, RTP, RTW
  - WR: CCD, WTR, WR
  - REF: RFC
  - PWR: XP

  A reloaded constraint with gap G delays a dependent command to exactly G cycles after the starting command. If a counter already holds a longer wait, it keeps it.
- R4: In every cycle after one without an issued non-sleep command, `bus_cmd` is NOP (0). Counters stop at zero and stay there until reloaded.
- R5: A SLP head command is consumed at once and never appears on the bus. When it carries N, no command is consumed for the next N cycles, so the next command can issue N+1 cycles after the sleep was consumed.
- R6: A write with `cfg_we` high takes effect from the next cycle. The address map is:
  - addresses 0..11 hold the constraint gaps, by constraint index;
  - address 12 holds the readiness threshold;
  - address 16+c holds the mask for command code c.
- R7: `ready_soon` is high when a non-sleep command is at the head, the remaining sleep count is below the threshold T, and every masked counter is below T. With T=1 this equals "issues this cycle".
- R8: After reset:
  - the bus carries NOP, no sleep is pending and all counters are zero;
  - the gaps are RCD 7, RAS 20, RC 27, RP 7, RRD 4, CCD 4, WTR 14, WR 18, RTP 4, RTW 7, XP 3 and RFC 44;
  - the threshold is 1 and the masks are the defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DRAM command clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration register address |
| cfg_wdata | input | 16 | Configuration write data |
| head_valid | input | 1 | Queue head holds a command |
| head_cmd | input | 3 | Code of the head command |
| head_arg | input | ADDR_W | Address of the head command, or cycle count for sleep |
| head_pop | output | 1 | Head command consumed this cycle |
| bus_cmd | output | 3 | Command driven on the DRAM bus |
| bus_addr | output | ADDR_W | Address driven on the DRAM bus |
| ready_soon | output | 1 | Head command will be free within the threshold |

## Verification
Several properties are checked by assertions in every cycle:
- no pop happens without a valid head;
- a consumed command had every masked counter at zero;
- the bus mirrors the consumed command one cycle later and carries NOP otherwise;
- a pending sleep blocks consumption;
- an idle counter stays at zero.

The exact gap lengths need the bench's command sequences to be observed:
- ACT to RD, RD to WR turnaround, WR to RD, activate-to-precharge, refresh recovery and power-down exit;
- the sleep stall length and where the readiness threshold changes;
- the effect of rewriting a gap or a mask at run time.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

    localparam int N_CON  = 12;
    localparam int N_CMD  = 8;
    localparam int CMD_W  = 3;
    localparam int CFG_AW = 5;
    localparam int CFG_DW = 16;

    typedef enum logic [CMD_W-1:0] {
        CMD_NOP = 3'd0,
        CMD_RD  = 3'd1,
        CMD_WR  = 3'd2,
        CMD_ACT = 3'd3,
        CMD_PRE = 3'd4,
        CMD_REF = 3'd5,
        CMD_PWR = 3'd6,
        CMD_SLP = 3'd7
    } cmd_e;

    localparam int K_RCD = 0;
    localparam int K_RAS = 1;
    localparam int K_RC  = 2;
    localparam int K_RP  = 3;
    localparam int K_RRD = 4;
    localparam int K_CCD = 5;
    localparam int K_WTR = 6;
    localparam int K_WR  = 7;
    localparam int K_RTP = 8;
    localparam int K_RTW = 9;
    localparam int K_XP  = 10;
    localparam int K_RFC = 11;

    localparam int THR_ADDR  = 12;
    localparam int MASK_BASE = 16;

    // Constraints whose counters a command starts when it issues.
    function automatic logic [N_CON-1:0] starts_of(logic [CMD_W-1:0] c);
        logic [N_CON-1:0] s;
        s = '0;
        case (c)
            CMD_ACT: begin s[K_RCD] = 1'b1; s[K_RAS] = 1'b1; s[K_RC] = 1'b1; s[K_RRD] = 1'b1; end
            CMD_PRE: s[K_RP] = 1'b1;
            CMD_RD:  begin s[K_CCD] = 1'b1; s[K_RTP] = 1'b1; s[K_RTW] = 1'b1; end
            CMD_WR:  begin s[K_CCD] = 1'b1; s[K_WTR] = 1'b1; s[K_WR] = 1'b1; end
            CMD_REF: s[K_RFC] = 1'b1;
            CMD_PWR: s[K_XP] = 1'b1;
            default: s = '0;
        endcase
        return s;
    endfunction

    // Boot value of the per-command wait mask.
    function automatic logic [N_CON-1:0] mask_boot(int c);
        logic [N_CON-1:0] m;
        m = '0;
        case (c)
            1: begin m[K_RCD] = 1'b1; m[K_CCD] = 1'b1; m[K_WTR] = 1'b1; m[K_XP] = 1'b1; end
            2: begin m[K_RCD] = 1'b1; m[K_CCD] = 1'b1; m[K_RTW] = 1'b1; m[K_XP] = 1'b1; end
            3: begin m[K_RP] = 1'b1; m[K_RC] = 1'b1; m[K_RRD] = 1'b1; m[K_RFC] = 1'b1; m[K_XP] = 1'b1; end
            4: begin m[K_RAS] = 1'b1; m[K_WR] = 1'b1; m[K_RTP] = 1'b1; m[K_XP] = 1'b1; end
            5: begin m[K_RP] = 1'b1; m[K_RC] = 1'b1; m[K_RFC] = 1'b1; m[K_XP] = 1'b1; end
            default: m = '0;
        endcase
        return m;
    endfunction

    // Boot gap, in cycles, between the starting and the dependent command.
    function automatic int gap_boot(int k);
        case (k)
            K_RCD: return 7;
            K_RAS: return 20;
            K_RC:  return 27;
            K_RP:  return 7;
            K_RRD: return 4;
            K_CCD: return 4;
            K_WTR: return 14;
            K_WR:  return 18;
            K_RTP: return 4;
            K_RTW: return 7;
            K_XP:  return 3;
            K_RFC: return 44;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/dtg_cfg_regs.sv
module dtg_cfg_regs
    import dtg_pkg::*;
#(
    parameter int TW = 6
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cfg_we,
    input  logic [CFG_AW-1:0]                 cfg_addr,
    input  logic [CFG_DW-1:0]                 cfg_wdata,
    output logic [N_CON-1:0][TW-1:0]          gap_o,
    output logic [TW-1:0]                     thr_o,
    output logic [N_CMD-1:0][N_CON-1:0]       mask_o
);

    typedef struct packed {
        logic [N_CON-1:0][TW-1:0]    gap;
        logic [TW-1:0]               thr;
        logic [N_CMD-1:0][N_CON-1:0] mask;
    } cfg_s;

    cfg_s cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            for (int k = 0; k < N_CON; k++) begin
                if (cfg_addr == CFG_AW'(k)) cfg_d.gap[k] = cfg_wdata[TW-1:0];
            end
            if (cfg_addr == CFG_AW'(THR_ADDR)) cfg_d.thr = cfg_wdata[TW-1:0];
            for (int c = 0; c < N_CMD; c++) begin
                if (cfg_addr == CFG_AW'(MASK_BASE + c)) cfg_d.mask[c] = cfg_wdata[N_CON-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < N_CON; k++) cfg_q.gap[k] <= TW'(gap_boot(k));
            cfg_q.thr <= TW'(1);
            for (int c = 0; c < N_CMD; c++) cfg_q.mask[c] <= mask_boot(c);
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign gap_o  = cfg_q.gap;
    assign thr_o  = cfg_q.thr;
    assign mask_o = cfg_q.mask;

endmodule

// File: rtl/dtg_counter_bank.sv
module dtg_counter_bank
    import dtg_pkg::*;
#(
    parameter int TW = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_CON-1:0][TW-1:0] gap_i,
    input  logic [N_CON-1:0]         load_i,
    output logic [N_CON-1:0][TW-1:0] cnt_o,
    output logic [N_CON-1:0]         zero_o
);

    typedef struct packed {
        logic [N_CON-1:0][TW-1:0] cnt;
    } bank_s;

    bank_s bank_d, bank_q;

    always_comb begin
        logic [TW-1:0] dec;
        logic [TW-1:0] tgt;
        bank_d = bank_q;
        for (int k = 0; k < N_CON; k++) begin
            dec = (bank_q.cnt[k] == '0) ? '0 : bank_q.cnt[k] - TW'(1);
            tgt = (gap_i[k] == '0) ? '0 : gap_i[k] - TW'(1);
            bank_d.cnt[k] = (load_i[k] && (tgt > dec)) ? tgt : dec;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    for (genvar k = 0; k < N_CON; k++) begin : g_zero
        assign zero_o[k] = (bank_q.cnt[k] == '0);
    end

    assign cnt_o = bank_q.cnt;

endmodule

// File: rtl/dtg_issue_ctrl.sv
module dtg_issue_ctrl
    import dtg_pkg::*;
#(
    parameter int TW     = 6,
    parameter int ADDR_W = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        head_valid,
    input  logic [CMD_W-1:0]            head_cmd,
    input  logic [ADDR_W-1:0]           head_arg,
    input  logic [N_CON-1:0]            zero_i,
    input  logic [N_CON-1:0][TW-1:0]    cnt_i,
    input  logic [N_CMD-1:0][N_CON-1:0] mask_i,
    input  logic [TW-1:0]               thr_i,
    output logic                        head_pop,
    output logic [N_CON-1:0]            load_o,
    output logic                        sleep_busy,
    output logic [CMD_W-1:0]            bus_cmd,
    output logic [ADDR_W-1:0]           bus_addr,
    output logic                        ready_soon
);

    localparam int SW = (ADDR_W > TW) ? ADDR_W : TW;

    typedef struct packed {
        logic [ADDR_W-1:0] sleep;
        logic [CMD_W-1:0]  cmd;
        logic [ADDR_W-1:0] addr;
    } ctl_s;

    ctl_s ctl_d, ctl_q;

    logic [N_CON-1:0] sel_mask;
    logic             all_clear;
    logic             is_slp;
    logic             issue;
    logic             take_slp;
    logic             near;

    always_comb begin
        sel_mask   = mask_i[head_cmd];
        all_clear  = &(zero_i | ~sel_mask);
        is_slp     = (head_cmd == CMD_SLP);
        sleep_busy = (ctl_q.sleep != '0);
        issue      = head_valid && !sleep_busy && !is_slp && all_clear;
        take_slp   = head_valid && !sleep_busy && is_slp;
        head_pop   = issue || take_slp;
        load_o     = issue ? starts_of(head_cmd) : '0;

        near = (SW'(ctl_q.sleep) < SW'(thr_i));
        for (int k = 0; k < N_CON; k++) begin
            if (sel_mask[k] && (cnt_i[k] >= thr_i)) near = 1'b0;
        end
        ready_soon = head_valid && !is_slp && near;

        ctl_d = ctl_q;
        if (take_slp)        ctl_d.sleep = head_arg;
        else if (sleep_busy) ctl_d.sleep = ctl_q.sleep - ADDR_W'(1);
        ctl_d.cmd  = issue ? head_cmd : CMD_NOP;
        ctl_d.addr = issue ? head_arg : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.sleep <= '0;
            ctl_q.cmd   <= CMD_NOP;
            ctl_q.addr  <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign bus_cmd  = ctl_q.cmd;
    assign bus_addr = ctl_q.addr;

endmodule

// File: rtl/dtg_timing_gate.sv
module dtg_timing_gate
    import dtg_pkg::*;
#(
    parameter int TW     = 6,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [4:0]        cfg_addr,
    input  logic [15:0]       cfg_wdata,
    input  logic              head_valid,
    input  logic [2:0]        head_cmd,
    input  logic [ADDR_W-1:0] head_arg,
    output logic              head_pop,
    output logic [2:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              ready_soon
);

    logic [N_CON-1:0][TW-1:0]    gap_tbl;
    logic [TW-1:0]               thr;
    logic [N_CMD-1:0][N_CON-1:0] mask_tbl;
    logic [N_CON-1:0][TW-1:0]    cnt;
    logic [N_CON-1:0]            cnt_zero;
    logic [N_CON-1:0]            load_vec;
    logic                        sleep_busy;

    dtg_cfg_regs #(.TW(TW)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .gap_o     (gap_tbl),
        .thr_o     (thr),
        .mask_o    (mask_tbl)
    );

    dtg_counter_bank #(.TW(TW)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .gap_i  (gap_tbl),
        .load_i (load_vec),
        .cnt_o  (cnt),
        .zero_o (cnt_zero)
    );

    dtg_issue_ctrl #(.TW(TW), .ADDR_W(ADDR_W)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .head_valid (head_valid),
        .head_cmd   (head_cmd),
        .head_arg   (head_arg),
        .zero_i     (cnt_zero),
        .cnt_i      (cnt),
        .mask_i     (mask_tbl),
        .thr_i      (thr),
        .head_pop   (head_pop),
        .load_o     (load_vec),
        .sleep_busy (sleep_busy),
        .bus_cmd    (bus_cmd),
        .bus_addr   (bus_addr),
        .ready_soon (ready_soon)
    );

endmodule

// File: rtl/dtg_timing_gate_chk.sv
module dtg_timing_gate_chk
    import dtg_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        head_valid,
    input logic [2:0]                  head_cmd,
    input logic [ADDR_W-1:0]           head_arg,
    input logic                        head_pop,
    input logic [2:0]                  bus_cmd,
    input logic [ADDR_W-1:0]           bus_addr,
    input logic [N_CON-1:0]            cnt_zero,
    input logic [N_CON-1:0]            load_vec,
    input logic [N_CMD-1:0][N_CON-1:0] mask_tbl,
    input logic                        sleep_busy
);

    logic fwd;
    assign fwd = head_pop && (head_cmd != CMD_SLP);

    a_r1_pop_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        head_pop |-> head_valid);

    a_r1_bus_follows: assert property (@(posedge clk) disable iff (!rst_n)
        fwd |=> (bus_cmd == $past(head_cmd) && bus_addr == $past(head_arg)));

    a_r2_masked_clear: assert property (@(posedge clk) disable iff (!rst_n)
        fwd |-> ((cnt_zero | ~mask_tbl[head_cmd]) == {N_CON{1'b1}}));

    a_r4_idle_nop: assert property (@(posedge clk) disable iff (!rst_n)
        !fwd |=> (bus_cmd == 3'd0));

    a_r5_sleep_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_busy |-> !head_pop);

    a_r5_sleep_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (head_pop && head_cmd == CMD_SLP && head_arg != '0) |=> sleep_busy);

    for (genvar k = 0; k < N_CON; k++) begin : g_sat
        a_r4_stays_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_zero[k] && !load_vec[k]) |=> cnt_zero[k]);
    end

endmodule

bind dtg_timing_gate dtg_timing_gate_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .head_valid (head_valid),
    .head_cmd   (head_cmd),
    .head_arg   (head_arg),
    .head_pop   (head_pop),
    .bus_cmd    (bus_cmd),
    .bus_addr   (bus_addr),
    .cnt_zero   (cnt_zero),
    .load_vec   (load_vec),
    .mask_tbl   (mask_tbl),
    .sleep_busy (sleep_busy)
);

// File: tb/dtg_timing_gate_tb_top.sv
module dtg_timing_gate_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 16;
    localparam int NV         = 14;

    typedef struct packed {
        logic [2:0]  cmd;
        logic [15:0] arg;
        logic [7:0]  gap;
    } vec_t;

    // command, argument, expected cycles since the previous consumption
    localparam vec_t VECS [NV] = '{
        '{3'd3, 16'h0011, 8'd1},
        '{3'd1, 16'h0020, 8'd7},
        '{3'd1, 16'h0024, 8'd4},
        '{3'd2, 16'h0028, 8'd7},
        '{3'd1, 16'h002c, 8'd14},
        '{3'd4, 16'h0011, 8'd4},
        '{3'd3, 16'h0012, 8'd7},
        '{3'd4, 16'h0012, 8'd20},
        '{3'd5, 16'h0000, 8'd7},
        '{3'd3, 16'h0013, 8'd44},
        '{3'd7, 16'd10,   8'd1},
        '{3'd1, 16'h0030, 8'd11},
        '{3'd6, 16'h0000, 8'd1},
        '{3'd1, 16'h0034, 8'd3}
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic              cfg_we;
    logic [4:0]        cfg_addr;
    logic [15:0]       cfg_wdata;
    logic              head_valid;
    logic [2:0]        head_cmd;
    logic [ADDR_W-1:0] head_arg;
    logic              head_pop;
    logic [2:0]        bus_cmd;
    logic [ADDR_W-1:0] bus_addr;
    logic              ready_soon;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dtg_timing_gate #(.ADDR_W(ADDR_W)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .head_valid (head_valid),
        .head_cmd   (head_cmd),
        .head_arg   (head_arg),
        .head_pop   (head_pop),
        .bus_cmd    (bus_cmd),
        .bus_addr   (bus_addr),
        .ready_soon (ready_soon)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Present a command until consumed; returns cycles since the last consumption.
    task automatic run_cmd(input logic [2:0] c, input logic [15:0] a, output int waited);
        waited = 0;
        do begin
            @(negedge clk);
            head_valid = 1'b1;
            head_cmd   = c;
            head_arg   = a;
            #1;
            waited++;
            if (!head_pop && waited == 2) check(bus_cmd == 3'd0, "R4 nop while stalled", bus_cmd, 0);
        end while (!head_pop && waited < 300);
        @(posedge clk);
        #1;
        head_valid = 1'b0;
        if (c == 3'd7) check(bus_cmd == 3'd0, "R5 sleep not on bus", bus_cmd, 0);
        else begin
            check(bus_cmd == c, "R1 bus command", bus_cmd, c);
            check(bus_addr == a, "R1 bus address", bus_addr, a);
        end
    endtask

    task automatic cfg_write(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic idle(input int n);
        head_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int w;
        rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        head_valid = 1'b0; head_cmd = '0; head_arg = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8: reset state
        check(bus_cmd == 3'd0, "R8 bus nop at reset", bus_cmd, 0);
        check(head_pop == 1'b0, "R8 no pop at reset", head_pop, 0);
        check(ready_soon == 1'b0, "R8 not ready without head", ready_soon, 0);
        rst_n = 1'b1;

        // Vector walk: R2 masks, R3 gaps, R5 sleep, R8 default values
        for (int i = 0; i < NV; i++) begin
            run_cmd(VECS[i].cmd, VECS[i].arg, w);
            check(w == int'(VECS[i].gap), $sformatf("R3 gap vector %0d", i), w, VECS[i].gap);
        end

        // R1/R4: no head, no pop, bus quiet
        idle(64);
        #1;
        check(head_pop == 1'b0, "R1 no pop without valid", head_pop, 0);
        check(bus_cmd == 3'd0, "R4 nop when idle", bus_cmd, 0);

        // R7: readiness threshold of 5 against RCD=7
        cfg_write(5'd12, 16'd5);
        run_cmd(3'd3, 16'h0040, w);
        for (int k = 1; k <= 7; k++) begin
            @(negedge clk);
            head_valid = 1'b1; head_cmd = 3'd1; head_arg = 16'h0044;
            #1;
            check(ready_soon == (k >= 3), $sformatf("R7 ready at step %0d", k), ready_soon, (k >= 3));
            check(head_pop == (k == 7), $sformatf("R2 pop at step %0d", k), head_pop, (k == 7));
        end
        @(posedge clk); #1; head_valid = 1'b0;
        cfg_write(5'd12, 16'd1);

        // R6: gap rewrite
        idle(64);
        cfg_write(5'd0, 16'd2);
        run_cmd(3'd3, 16'h0050, w);
        run_cmd(3'd1, 16'h0054, w);
        check(w == 2, "R6 rewritten RCD gap", w, 2);

        // R6: mask rewrite, RD waits on nothing
        idle(64);
        cfg_write(5'd17, 16'd0);
        run_cmd(3'd3, 16'h0060, w);
        run_cmd(3'd1, 16'h0064, w);
        check(w == 1, "R6 cleared RD mask", w, 1);

        // R5: zero-length sleep and a short sleep
        idle(64);
        run_cmd(3'd7, 16'd0, w);
        run_cmd(3'd6, 16'h0000, w);
        check(w == 1, "R5 zero sleep", w, 1);
        run_cmd(3'd7, 16'd3, w);
        run_cmd(3'd6, 16'h0000, w);
        check(w == 4, "R5 sleep of three", w, 4);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule